// File: doc/BRIEF.md
# Auto-Incrementing Shared RAM Host Port

This block lets a byte-wide host reach a coprocessor's shared RAM without a direct address bus. The host loads a 16-bit pointer one byte at a time through two address registers, then moves bytes through a single data register. Each data access reads or writes the RAM byte under the pointer. With auto-increment enabled, the pointer moves forward after every data access. A whole code image can therefore be uploaded, downloaded or compared after one pointer load.

A combined control/status register sits next to the pointer. It holds the controls that the coprocessor sees: run, bypass and an interrupt request toward the coprocessor. It also holds two event flags that the coprocessor raises toward the host. The host clears these flags by writing ones to them. The coprocessor core is not part of this block. It appears here only as pins: event set pulses, an acknowledge for the request bit, and a write port into the RAM, which it uses, for example, to set a liveness byte that the host later checks and clears.

Host requests use a valid/ready handshake. Read results return on a valid/ready response channel that holds one entry. A request is accepted only while that entry is empty or is being drained in the same cycle, so a stalled response stops new requests. The coprocessor write port is also valid/ready. It is refused in any cycle where the host is writing the RAM.

Top module: `shram_host_port`

## Requirements
- R1: After reset the control/status register reads 0x00, both address registers read 0x00, and cop_run, cop_bypass, cop_irq, host_int and host_rsp_valid are all low.
- R2: host_req_sel selects the register: 0 is control/status, 1 is address low byte, 2 is address high byte, 3 is data. Writing select 1 or 2 replaces only that byte of the pointer. Reading select 1 or 2 returns that byte of the current pointer.
- R3: A data-port write stores the byte at the current pointer. A data-port read returns the byte at the current pointer, including the first read after an address load. The RAM index is the low MEM_AW bits of the pointer.
- R4: When AUTOINC (control bit 1) is set, every data-port read or write advances the pointer by one. When AUTOINC is clear, the pointer does not move, and repeated reads return the same byte.
- R5: An increment from pointer 0xFFFF gives 0x0000.
- R6: A control write loads RUN (bit 0), AUTOINC (bit 1) and BYPASS (bit 2) from the written byte. cop_run follows RUN and cop_bypass follows BYPASS. Writing RUN as 0 halts the coprocessor and leaves the other written bits as written.
- R7: Writing 1 to IRQ (bit 3) raises cop_irq. Writing 0 to IRQ has no effect. cop_irq_ack clears IRQ unless a write of 1 to IRQ happens in the same cycle, in which case the set wins.
- R8: A pulse on cop_set_int0 or cop_set_int1 sets INT0 (bit 4) or INT1 (bit 5). host_int is the OR of the two flags. Writing 1 to a flag clears it, and that same write also forces RUN and AUTOINC to 1. Writing 0 to a flag leaves it unchanged. A set in the same cycle as a clear wins.
- R9: Each accepted read produces one response on the cycle after acceptance. While host_rsp_valid is high and host_rsp_ready is low, the response data stays stable and host_req_ready is low.
- R10: The coprocessor write port stores cop_wr_data at cop_wr_addr when cop_wr_valid and cop_wr_ready are both high. cop_wr_ready is low in a cycle where the host writes the data port. A byte written this way, such as 0xFF at a liveness address, reads back through the data port, and the host can overwrite it with 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_req_valid | input | 1 | Host request present |
| host_req_ready | output | 1 | Host request accepted this cycle |
| host_req_write | input | 1 | 1 = write, 0 = read |
| host_req_sel | input | 2 | Register select (0 ctrl, 1 addr low, 2 addr high, 3 data) |
| host_req_wdata | input | 8 | Write byte |
| host_rsp_valid | output | 1 | Read result present |
| host_rsp_ready | input | 1 | Host takes the read result |
| host_rsp_data | output | 8 | Read result byte |
| host_int | output | 1 | Either coprocessor event flag set |
| cop_run | output | 1 | Coprocessor run enable |
| cop_bypass | output | 1 | Coprocessor bypass mode |
| cop_irq | output | 1 | Interrupt request toward the coprocessor |
| cop_irq_ack | input | 1 | Coprocessor acknowledges the request |
| cop_set_int0 | input | 1 | Coprocessor raises event flag 0 |
| cop_set_int1 | input | 1 | Coprocessor raises event flag 1 |
| cop_wr_valid | input | 1 | Coprocessor RAM write request |
| cop_wr_ready | output | 1 | Coprocessor RAM write accepted |
| cop_wr_addr | input | 16 | Coprocessor RAM write address |
| cop_wr_data | input | 8 | Coprocessor RAM write byte |

## Verification
The data port is tested with a block written and then read back under auto-increment. This separates a pointer that steps correctly from one that stays put or steps on address writes. The data port is then read repeatedly with auto-increment off, which shows whether a read moves the pointer. A pointer loaded at 0xFFFF tests the wrap to 0x0000, and a read that follows a store with no increment tests the forwarding path into the prefetch register. The control byte is tested with write patterns that differ only in RUN, only in IRQ, or only in the flag bits, and with event pulses that arrive in the same cycle as a clear. A stalled response and a coprocessor write that collides with a host data write test the two handshakes.

// File: rtl/shram_pkg.sv
package shram_pkg;

  typedef enum logic [1:0] {
    SEL_CTRL    = 2'd0,
    SEL_ADDR_LO = 2'd1,
    SEL_ADDR_HI = 2'd2,
    SEL_DATA    = 2'd3
  } reg_sel_e;

  localparam int CTRL_W = 6;

  // bit 0 run .. bit 5 int1, as seen in the host read byte
  typedef struct packed {
    logic int1;
    logic int0;
    logic irq;
    logic bypass;
    logic autoinc;
    logic run;
  } ctrl_t;

endpackage

// File: rtl/shram_ctrl_reg.sv
module shram_ctrl_reg
  import shram_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [CTRL_W-1:0] wdata,
  input  logic              set_int0,
  input  logic              set_int1,
  input  logic              irq_ack,
  output ctrl_t             ctrl_q
);

  ctrl_t wv;
  ctrl_t ctrl_d;
  logic  flag_clr;

  always_comb begin
    wv       = ctrl_t'(wdata);
    flag_clr = wr_en && (wv.int0 || wv.int1);
    ctrl_d   = ctrl_q;
    if (wr_en) begin
      ctrl_d.run     = wv.run     | flag_clr;
      ctrl_d.autoinc = wv.autoinc | flag_clr;
      ctrl_d.bypass  = wv.bypass;
    end
    // request toward coprocessor: host sets, ack clears, set wins
    if (irq_ack)             ctrl_d.irq = 1'b0;
    if (wr_en && wv.irq)     ctrl_d.irq = 1'b1;
    // event flags: write-one-to-clear, coprocessor set wins
    if (wr_en && wv.int0)    ctrl_d.int0 = 1'b0;
    if (wr_en && wv.int1)    ctrl_d.int1 = 1'b0;
    if (set_int0)            ctrl_d.int0 = 1'b1;
    if (set_int1)            ctrl_d.int1 = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) ctrl_q <= '0;
    else        ctrl_q <= ctrl_d;
  end

endmodule

// File: rtl/shram_addr_ptr.sv
module shram_addr_ptr #(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_lo,
  input  logic              wr_hi,
  input  logic [7:0]        wdata,
  input  logic              step,
  output logic [ADDR_W-1:0] ptr_q,
  output logic [ADDR_W-1:0] ptr_nxt
);

  localparam int HI_W = ADDR_W - 8;

  always_comb begin
    ptr_nxt = ptr_q;
    if (wr_lo)      ptr_nxt = {ptr_q[ADDR_W-1:8], wdata};
    else if (wr_hi) ptr_nxt = {wdata[HI_W-1:0], ptr_q[7:0]};
    else if (step)  ptr_nxt = ptr_q + ADDR_W'(1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) ptr_q <= '0;
    else        ptr_q <= ptr_nxt;
  end

endmodule

// File: rtl/shram_mem.sv
module shram_mem #(
  parameter int MEM_AW = 11,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [MEM_AW-1:0] wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [MEM_AW-1:0] rd_idx,
  output logic [DATA_W-1:0] rd_q
);

  localparam int DEPTH = 1 << MEM_AW;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_idx] <= wr_data;
  end

  // prefetch of the byte the pointer will hold next cycle, with forwarding
  always_ff @(posedge clk) begin
    if (!rst_n)                          rd_q <= '0;
    else if (wr_en && wr_idx == rd_idx)  rd_q <= wr_data;
    else                                 rd_q <= mem[rd_idx];
  end

endmodule

// File: rtl/shram_host_port.sv
module shram_host_port
  import shram_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int MEM_AW = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_req_valid,
  output logic              host_req_ready,
  input  logic              host_req_write,
  input  logic [1:0]        host_req_sel,
  input  logic [7:0]        host_req_wdata,
  output logic              host_rsp_valid,
  input  logic              host_rsp_ready,
  output logic [7:0]        host_rsp_data,
  output logic              host_int,
  output logic              cop_run,
  output logic              cop_bypass,
  output logic              cop_irq,
  input  logic              cop_irq_ack,
  input  logic              cop_set_int0,
  input  logic              cop_set_int1,
  input  logic              cop_wr_valid,
  output logic              cop_wr_ready,
  input  logic [ADDR_W-1:0] cop_wr_addr,
  input  logic [7:0]        cop_wr_data
);

  localparam int HI_W = ADDR_W - 8;

  reg_sel_e          sel;
  logic              req_fire;
  logic              ctrl_wr;
  logic              addr_lo_wr;
  logic              addr_hi_wr;
  logic              data_acc;
  logic              host_ram_wr;
  logic              ptr_step;
  ctrl_t             ctrl_q;
  logic [ADDR_W-1:0] ptr_q;
  logic [ADDR_W-1:0] ptr_nxt;
  logic              mem_wr_en;
  logic [MEM_AW-1:0] mem_wr_idx;
  logic [7:0]        mem_wr_data;
  logic [7:0]        pf_data;
  logic [7:0]        rd_mux;
  logic              rsp_valid_q;
  logic [7:0]        rsp_data_q;
  logic              unused_hi;

  assign sel            = reg_sel_e'(host_req_sel);
  assign host_req_ready = !rsp_valid_q || host_rsp_ready;
  assign req_fire       = host_req_valid && host_req_ready;
  assign ctrl_wr        = req_fire && host_req_write && sel == SEL_CTRL;
  assign addr_lo_wr     = req_fire && host_req_write && sel == SEL_ADDR_LO;
  assign addr_hi_wr     = req_fire && host_req_write && sel == SEL_ADDR_HI;
  assign data_acc       = req_fire && sel == SEL_DATA;
  assign host_ram_wr    = data_acc && host_req_write;
  assign ptr_step       = data_acc && ctrl_q.autoinc;

  shram_ctrl_reg u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (ctrl_wr),
    .wdata    (host_req_wdata[CTRL_W-1:0]),
    .set_int0 (cop_set_int0),
    .set_int1 (cop_set_int1),
    .irq_ack  (cop_irq_ack),
    .ctrl_q   (ctrl_q)
  );

  shram_addr_ptr #(.ADDR_W(ADDR_W)) u_ptr (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_lo   (addr_lo_wr),
    .wr_hi   (addr_hi_wr),
    .wdata   (host_req_wdata),
    .step    (ptr_step),
    .ptr_q   (ptr_q),
    .ptr_nxt (ptr_nxt)
  );

  // host data write owns the single write port; coprocessor waits
  assign cop_wr_ready = !host_ram_wr;
  assign mem_wr_en    = host_ram_wr || cop_wr_valid;
  assign mem_wr_idx   = host_ram_wr ? ptr_q[MEM_AW-1:0] : cop_wr_addr[MEM_AW-1:0];
  assign mem_wr_data  = host_ram_wr ? host_req_wdata : cop_wr_data;
  assign unused_hi    = ^{cop_wr_addr[ADDR_W-1:MEM_AW], host_req_wdata[7:CTRL_W]};

  shram_mem #(.MEM_AW(MEM_AW), .DATA_W(8)) u_mem (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (mem_wr_en),
    .wr_idx  (mem_wr_idx),
    .wr_data (mem_wr_data),
    .rd_idx  (ptr_nxt[MEM_AW-1:0]),
    .rd_q    (pf_data)
  );

  always_comb begin
    unique case (sel)
      SEL_CTRL:    rd_mux = {{(8-CTRL_W){1'b0}}, ctrl_q};
      SEL_ADDR_LO: rd_mux = ptr_q[7:0];
      SEL_ADDR_HI: rd_mux = 8'(ptr_q[ADDR_W-1:ADDR_W-HI_W]);
      default:     rd_mux = pf_data;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid_q <= 1'b0;
      rsp_data_q  <= '0;
    end else if (req_fire && !host_req_write) begin
      rsp_valid_q <= 1'b1;
      rsp_data_q  <= rd_mux;
    end else if (host_rsp_ready) begin
      rsp_valid_q <= 1'b0;
    end
  end

  assign host_rsp_valid = rsp_valid_q;
  assign host_rsp_data  = rsp_data_q;
  assign host_int       = ctrl_q.int0 || ctrl_q.int1;
  assign cop_run        = ctrl_q.run;
  assign cop_bypass     = ctrl_q.bypass;
  assign cop_irq        = ctrl_q.irq;

endmodule

// File: rtl/shram_host_port_chk.sv
module shram_host_port_chk #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              host_rsp_valid,
  input logic              host_rsp_ready,
  input logic [7:0]        host_rsp_data,
  input logic              cop_irq,
  input logic              cop_irq_ack,
  input logic              ctrl_wr,
  input logic [7:0]        wdata,
  input logic              cop_set_int0,
  input logic              cop_set_int1,
  input logic              host_int,
  input logic [ADDR_W-1:0] ptr_q,
  input logic              data_acc,
  input logic              addr_wr,
  input logic              autoinc
);

  // R9
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    host_rsp_valid && !host_rsp_ready |=> host_rsp_valid && $stable(host_rsp_data));

  // R7
  irq_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cop_irq_ack && !(ctrl_wr && wdata[3]) |=> !cop_irq);

  // R8
  int_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cop_set_int0 || cop_set_int1 |=> host_int);

  // R4
  ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !data_acc && !addr_wr |=> $stable(ptr_q));

  // R4
  ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    data_acc && autoinc |=> ptr_q == ADDR_W'($past(ptr_q) + 1'b1));

  // R5
  ptr_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    data_acc && autoinc && (&ptr_q) |=> ptr_q == '0);

endmodule

bind shram_host_port shram_host_port_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .host_rsp_valid (host_rsp_valid),
  .host_rsp_ready (host_rsp_ready),
  .host_rsp_data  (host_rsp_data),
  .cop_irq        (cop_irq),
  .cop_irq_ack    (cop_irq_ack),
  .ctrl_wr        (ctrl_wr),
  .wdata          (host_req_wdata),
  .cop_set_int0   (cop_set_int0),
  .cop_set_int1   (cop_set_int1),
  .host_int       (host_int),
  .ptr_q          (ptr_q),
  .data_acc       (data_acc),
  .addr_wr        (addr_lo_wr || addr_hi_wr),
  .autoinc        (ctrl_q.autoinc)
);

// File: tb/shram_host_port_bench.sv
`timescale 1ns/1ps
module shram_host_port_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_req_valid = 1'b0;
  logic        host_req_ready;
  logic        host_req_write = 1'b0;
  logic [1:0]  host_req_sel = 2'd0;
  logic [7:0]  host_req_wdata = 8'h00;
  logic        host_rsp_valid;
  logic        host_rsp_ready = 1'b1;
  logic [7:0]  host_rsp_data;
  logic        host_int;
  logic        cop_run;
  logic        cop_bypass;
  logic        cop_irq;
  logic        cop_irq_ack = 1'b0;
  logic        cop_set_int0 = 1'b0;
  logic        cop_set_int1 = 1'b0;
  logic        cop_wr_valid = 1'b0;
  logic        cop_wr_ready;
  logic [15:0] cop_wr_addr = 16'h0;
  logic [7:0]  cop_wr_data = 8'h00;

  int checks = 0;
  int errors = 0;

  typedef struct {
    logic [7:0] data;
    string      tag;
  } exp_t;
  exp_t exp_q[$];

  always #2.5 clk = ~clk;

  shram_host_port u_shram_host_port (.*);

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  // monitor: pops the scoreboard as responses leave the block
  always @(negedge clk) begin
    if (rst_n && host_rsp_valid && host_rsp_ready) begin
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R9 unexpected response actual=%02h expected=none", host_rsp_data);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        check(e.tag, host_rsp_data, e.data);
      end
    end
  end

  task automatic bus(input logic wr, input logic [1:0] sel, input logic [7:0] d);
    @(negedge clk);
    host_req_valid = 1'b1; host_req_write = wr; host_req_sel = sel; host_req_wdata = d;
    while (!host_req_ready) @(negedge clk);
    @(negedge clk);
    host_req_valid = 1'b0; host_req_write = 1'b0;
  endtask

  task automatic wr(input logic [1:0] sel, input logic [7:0] d);
    bus(1'b1, sel, d);
  endtask

  task automatic rd(input logic [1:0] sel, input logic [7:0] e, input string tag);
    exp_t x;
    x.data = e; x.tag = tag;
    exp_q.push_back(x);
    bus(1'b0, sel, 8'h00);
  endtask

  task automatic load(input logic [15:0] a);
    wr(2'd1, a[7:0]);
    wr(2'd2, a[15:8]);
  endtask

  task automatic cop_write(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    cop_wr_valid = 1'b1; cop_wr_addr = a; cop_wr_data = d;
    while (!cop_wr_ready) @(negedge clk);
    @(negedge clk);
    cop_wr_valid = 1'b0;
  endtask

  initial begin
    #(5.0 * 100000);
    checks++; errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 cop_run", {7'd0, cop_run}, 8'h00);
    check("R1 cop_bypass", {7'd0, cop_bypass}, 8'h00);
    check("R1 cop_irq", {7'd0, cop_irq}, 8'h00);
    check("R1 host_int", {7'd0, host_int}, 8'h00);
    check("R1 rsp_valid", {7'd0, host_rsp_valid}, 8'h00);
    rd(2'd0, 8'h00, "R1 ctrl");
    rd(2'd1, 8'h00, "R1 addr lo");
    rd(2'd2, 8'h00, "R1 addr hi");

    // R2 address bytes
    load(16'h1234);
    rd(2'd1, 8'h34, "R2 addr lo");
    rd(2'd2, 8'h12, "R2 addr hi");

    // R3 R4 block upload then download
    wr(2'd0, 8'h02);
    load(16'h0010);
    for (int i = 0; i < 4; i++) wr(2'd3, 8'hA0 + 8'(i));
    rd(2'd1, 8'h14, "R4 pointer after four writes");
    load(16'h0010);
    for (int i = 0; i < 4; i++) rd(2'd3, 8'hA0 + 8'(i), "R3 block read");

    // R4 no auto-increment
    wr(2'd0, 8'h00);
    load(16'h0011);
    rd(2'd3, 8'hA1, "R4 hold read 1");
    rd(2'd3, 8'hA1, "R4 hold read 2");
    rd(2'd1, 8'h11, "R4 pointer held");
    // R3 store then read, no increment: forwarded value
    wr(2'd3, 8'hC3);
    rd(2'd3, 8'hC3, "R3 read after write in place");

    // R5 wrap
    wr(2'd0, 8'h02);
    load(16'hFFFF);
    wr(2'd3, 8'h5A);
    rd(2'd1, 8'h00, "R5 wrap lo");
    rd(2'd2, 8'h00, "R5 wrap hi");
    load(16'hFFFF);
    rd(2'd3, 8'h5A, "R5 byte at top");

    // R9 back-pressure
    load(16'h0010);
    @(posedge clk); #1 host_rsp_ready = 1'b0;
    rd(2'd3, 8'hA0, "R9 stalled response");
    repeat (3) @(negedge clk);
    check("R9 req_ready low", {7'd0, host_req_ready}, 8'h00);
    check("R9 rsp_valid held", {7'd0, host_rsp_valid}, 8'h01);
    check("R9 rsp_data held", host_rsp_data, 8'hA0);
    @(posedge clk); #1 host_rsp_ready = 1'b1;
    rd(2'd3, 8'hC3, "R9 next after release");

    // R6 control bits
    wr(2'd0, 8'h07);
    check("R6 run on", {7'd0, cop_run}, 8'h01);
    check("R6 bypass on", {7'd0, cop_bypass}, 8'h01);
    rd(2'd0, 8'h07, "R6 ctrl readback");
    wr(2'd0, 8'h06);
    check("R6 run off", {7'd0, cop_run}, 8'h00);
    rd(2'd0, 8'h06, "R6 others kept");

    // R7 request bit
    wr(2'd0, 8'h0E);
    check("R7 irq set", {7'd0, cop_irq}, 8'h01);
    wr(2'd0, 8'h06);
    check("R7 irq write 0 ignored", {7'd0, cop_irq}, 8'h01);
    @(negedge clk) cop_irq_ack = 1'b1;
    @(negedge clk) cop_irq_ack = 1'b0;
    check("R7 irq cleared by ack", {7'd0, cop_irq}, 8'h00);
    @(negedge clk) cop_irq_ack = 1'b1;
    wr(2'd0, 8'h0E);
    cop_irq_ack = 1'b0;
    check("R7 set wins over ack", {7'd0, cop_irq}, 8'h01);
    @(negedge clk) cop_irq_ack = 1'b1;
    @(negedge clk) cop_irq_ack = 1'b0;

    // R8 event flags
    wr(2'd0, 8'h00);
    @(negedge clk) cop_set_int0 = 1'b1;
    @(negedge clk) cop_set_int0 = 1'b0;
    check("R8 host_int", {7'd0, host_int}, 8'h01);
    rd(2'd0, 8'h10, "R8 int0 set");
    wr(2'd0, 8'h10);
    check("R8 host_int cleared", {7'd0, host_int}, 8'h00);
    check("R8 run forced", {7'd0, cop_run}, 8'h01);
    rd(2'd0, 8'h03, "R8 clear sets run and autoinc");
    @(negedge clk) cop_set_int1 = 1'b1;
    @(negedge clk) cop_set_int1 = 1'b0;
    wr(2'd0, 8'h00);
    rd(2'd0, 8'h20, "R8 write 0 keeps flag");
    @(negedge clk) cop_set_int1 = 1'b1;
    wr(2'd0, 8'h20);
    cop_set_int1 = 1'b0;
    rd(2'd0, 8'h23, "R8 set wins over clear");
    wr(2'd0, 8'h20);
    rd(2'd0, 8'h03, "R8 cleared");

    // R10 liveness byte and port conflict
    cop_write(16'h0400, 8'hFF);
    load(16'h0400);
    rd(2'd3, 8'hFF, "R10 liveness set");
    load(16'h0400);
    wr(2'd3, 8'h00);
    load(16'h0400);
    rd(2'd3, 8'h00, "R10 liveness cleared");
    load(16'h0020);
    @(negedge clk);
    host_req_valid = 1'b1; host_req_write = 1'b1; host_req_sel = 2'd3; host_req_wdata = 8'h66;
    cop_wr_valid = 1'b1; cop_wr_addr = 16'h0030; cop_wr_data = 8'h77;
    #1 check("R10 cop refused on conflict", {7'd0, cop_wr_ready}, 8'h00);
    @(negedge clk);
    host_req_valid = 1'b0; host_req_write = 1'b0;
    #1 check("R10 cop accepted after", {7'd0, cop_wr_ready}, 8'h01);
    @(negedge clk) cop_wr_valid = 1'b0;
    load(16'h0020);
    rd(2'd3, 8'h66, "R10 host byte");
    load(16'h0030);
    rd(2'd3, 8'h77, "R10 cop byte");

    repeat (4) @(negedge clk);
    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL R9 missing responses actual=%0d expected=0", exp_q.size());
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule